// File: doc/BRIEF.md
# Open-Switch Fault Locator for a Nine-Switch Direct AC Converter

This block watches the three output phase currents of a direct three-by-three AC converter, sample by sample. It names the one bidirectional switch that has failed open. It needs no voltage sensing. It uses only the measured phase currents, the current-loop errors and the number of the input-voltage sector (1 to 12) the source angle lies in.

Detection runs in two steps. First, an output phase whose current stays near zero for too many samples is taken as the suspect output. From then on only the three switches tied to that phase remain candidates. Second, starting at the next entry into sector 1, the block sums the absolute current error of the suspect phase over one whole source period. It keeps three separate sums, one per group of four sectors. The group with the smallest sum names the input phase of the faulty switch. The result is latched until reset.

Top module: `open_switch_locator`

## Requirements
- R1: After reset `fault_vld` is 0 and `fault_idx` is 15, and `fault_idx` stays 15 whenever `fault_vld` is 0.
- R2: A phase current counts as zero when its magnitude is at most `DEAD_BAND`, for either sign; a magnitude of `DEAD_BAND`+1 does not count.
- R3: A phase becomes the suspect output when its current counts as zero on `ZERO_RUN` consecutive valid samples; a shorter run alone does not.
- R4: A valid sample with the current outside the dead band clears that phase's run count to zero.
- R5: Accumulation starts on the first valid sample with `sector`=1 whose previous valid sample had another sector, and includes that sample. The verdict is taken on the next such sample once all 12 sectors have been seen, and that sample is not summed. `fault_vld` rises on the clock edge that takes this sample.
- R6: Sectors 1, 2, 7, 8 feed group 0 (input A); sectors 5, 6, 11, 12 feed group 1 (input B); sectors 3, 4, 9, 10 feed group 2 (input C). The group with the smallest sum of |error| of the suspect phase is the faulty input.
- R7: `fault_idx` = output phase × 3 + input phase, with outputs a=0, b=1, c=2 and inputs A=0, B=1, C=2, so values 0 to 8.
- R8: When group sums are equal, the lowest-numbered group among the smallest wins.
- R9: Each group sum saturates at 2^`ACC_W`−1 instead of wrapping.
- R10: Once `fault_vld` is 1, it and `fault_idx` hold until reset, whatever the inputs do.
- R11: If several phases complete their zero run on the same sample, the lowest-numbered phase is the suspect.
- R12: Cycles with `smp_vld` low change nothing: no run count, no sector history, no sum and no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | One current-loop sample is present this cycle |
| sector | input | 4 | Input-voltage sector number, 1 to 12 |
| cur_a | input | CUR_W | Output phase a current, signed |
| cur_b | input | CUR_W | Output phase b current, signed |
| cur_c | input | CUR_W | Output phase c current, signed |
| err_a | input | CUR_W | Phase a current error (reference minus measured), signed |
| err_b | input | CUR_W | Phase b current error, signed |
| err_c | input | CUR_W | Phase c current error, signed |
| fault_vld | output | 1 | Faulty switch located; latched |
| fault_idx | output | 4 | Faulty switch index 0 to 8, or 15 for none |

## Verification
The bench builds the block with 8-bit currents, a dead band of 3, a zero-run threshold of 4 and 8-bit group sums. With these values every output-phase and input-phase pairing can be swept in a run of a few dozen samples. The edges of the dead band and of the run threshold sit one sample or one count apart. Errors of at most 127 on eight samples per group reach the 255 ceiling of a sum, so saturation can be told apart from wrap-around. Ties, simultaneous suspects, idle gaps and the hold after a verdict are all reached in the same small setting.

// File: rtl/osl_pkg.sv
// Package: shared types and sector-to-group mapping for the open-switch
// fault locator. Assumes sector numbers 1..12; anything else maps to "none".
package osl_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,   // stage one: waiting for a suspect output phase
        ST_ARM   = 2'd1,   // suspect known, waiting for a sector-1 entry
        ST_ACC   = 2'd2,   // stage two: summing grouped |error|
        ST_HOLD  = 2'd3    // verdict latched
    } loc_state_t;

    localparam int          NUM_PH   = 3;
    localparam int          NUM_SEC  = 12;
    localparam logic [3:0]  NO_FAULT = 4'd15;
    localparam logic [1:0]  GRP_NONE = 2'd3;

    // Map a sector to the input phase whose switches are unaffected there.
    function automatic logic [1:0] sec_group(input logic [3:0] sec);
        case (sec)
            4'd1, 4'd2, 4'd7, 4'd8:    return 2'd0;
            4'd5, 4'd6, 4'd11, 4'd12:  return 2'd1;
            4'd3, 4'd4, 4'd9, 4'd10:   return 2'd2;
            default:                   return GRP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/zero_run_det.sv
// Zero-run detector: counts consecutive valid samples whose current lies
// inside the dead band and flags when the count reaches ZERO_RUN.
// Assumes DEAD_BAND fits in CUR_W-1 bits. The count saturates at ZERO_RUN.
module zero_run_det #(
    parameter int CUR_W     = 12,
    parameter int DEAD_BAND = 8,
    parameter int ZERO_RUN  = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [CUR_W-1:0] cur,
    output logic                    run_full
);
    localparam int CNT_W = $clog2(ZERO_RUN + 1);

    logic [CUR_W-1:0] mag;
    logic             in_band;
    logic [CNT_W-1:0] cnt;

    // Magnitude of the signed current and dead-band test.
    always_comb begin
        mag     = cur[CUR_W-1] ? CUR_W'(-cur) : CUR_W'(cur);
        in_band = (mag <= CUR_W'(DEAD_BAND));
    end

    // Consecutive in-band sample counter, cleared by any out-of-band sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (smp_vld) begin
            if (!in_band)
                cnt <= '0;
            else if (cnt != CNT_W'(ZERO_RUN))
                cnt <= cnt + 1'b1;
        end
    end

    assign run_full = (cnt == CNT_W'(ZERO_RUN));

endmodule

// File: rtl/err_group_acc.sv
// Grouped error accumulator: three saturating sums of |err|, one per sector
// group, plus the index of the smallest sum (ties go to the lower index).
// Assumes ACC_W >= ERR_W so that one magnitude always fits a sum.
module err_group_acc #(
    parameter int ERR_W = 12,
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    add,
    input  logic [1:0]              grp,
    input  logic signed [ERR_W-1:0] err,
    output logic [1:0]              best_grp
);
    localparam logic [ACC_W-1:0] SUM_MAX = {ACC_W{1'b1}};

    logic [ERR_W-1:0] mag;
    logic [ACC_W-1:0] sum [3];

    // Absolute value of the incoming error.
    always_comb mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);

    for (genvar g = 0; g < 3; g++) begin : g_sum
        logic [ACC_W:0] wide;

        // One extra bit to spot the carry out of the sum.
        always_comb wide = {1'b0, sum[g]} + (ACC_W+1)'(mag);

        // Per-group sum: restart on load, saturating add on its own sectors.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sum[g] <= '0;
            else if (load)
                sum[g] <= (grp == 2'(g)) ? ACC_W'(mag) : '0;
            else if (add && grp == 2'(g))
                sum[g] <= wide[ACC_W] ? SUM_MAX : wide[ACC_W-1:0];
        end
    end

    // Smallest sum, lowest group index winning ties.
    always_comb begin
        if (sum[0] <= sum[1] && sum[0] <= sum[2])
            best_grp = 2'd0;
        else if (sum[1] <= sum[2])
            best_grp = 2'd1;
        else
            best_grp = 2'd2;
    end

endmodule

// File: rtl/open_switch_locator.sv
// Open-switch fault locator, top level. Stage one picks a suspect output
// phase from a long near-zero current run; stage two sums that phase's
// |error| over one source period in three sector groups and names the
// input phase with the smallest sum. Assumes one sample per smp_vld pulse
// and a sector number that advances 1..12 around the source period.
module open_switch_locator
    import osl_pkg::*;
#(
    parameter int CUR_W     = 12,
    parameter int DEAD_BAND = 8,
    parameter int ZERO_RUN  = 30,
    parameter int ACC_W     = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic [3:0]              sector,
    input  logic signed [CUR_W-1:0] cur_a,
    input  logic signed [CUR_W-1:0] cur_b,
    input  logic signed [CUR_W-1:0] cur_c,
    input  logic signed [CUR_W-1:0] err_a,
    input  logic signed [CUR_W-1:0] err_b,
    input  logic signed [CUR_W-1:0] err_c,
    output logic                    fault_vld,
    output logic [3:0]              fault_idx
);
    localparam logic [NUM_SEC-1:0] ALL_SEEN = {NUM_SEC{1'b1}};

    loc_state_t              state;
    logic signed [CUR_W-1:0] cur_v [NUM_PH];
    logic [NUM_PH-1:0]       run_full;
    logic [1:0]              suspect;
    logic [1:0]              first_ph;
    logic signed [CUR_W-1:0] sus_err;
    logic [3:0]              prev_sec;
    logic [NUM_SEC-1:0]      seen;
    logic [NUM_SEC-1:0]      sec_bit;
    logic [1:0]              grp;
    logic [1:0]              best_grp;
    logic                    boundary;
    logic                    acc_load;
    logic                    acc_add;
    logic                    decide;

    assign cur_v[0] = cur_a;
    assign cur_v[1] = cur_b;
    assign cur_v[2] = cur_c;

    // Stage one: one zero-run detector per output phase.
    for (genvar p = 0; p < NUM_PH; p++) begin : g_zrun
        zero_run_det #(
            .CUR_W     (CUR_W),
            .DEAD_BAND (DEAD_BAND),
            .ZERO_RUN  (ZERO_RUN)
        ) u_zrun (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_vld  (smp_vld),
            .cur      (cur_v[p]),
            .run_full (run_full[p])
        );
    end

    // Lowest-numbered phase among those with a complete zero run.
    always_comb begin
        if (run_full[0])      first_ph = 2'd0;
        else if (run_full[1]) first_ph = 2'd1;
        else                  first_ph = 2'd2;
    end

    // Error of the suspect phase feeds stage two.
    always_comb begin
        case (suspect)
            2'd0:    sus_err = err_a;
            2'd1:    sus_err = err_b;
            default: sus_err = err_c;
        endcase
    end

    // Sector decoding: group, one-hot sector bit, sector-1 entry.
    always_comb begin
        grp      = sec_group(sector);
        sec_bit  = (grp != GRP_NONE) ? (NUM_SEC'(1) << (sector - 4'd1)) : '0;
        boundary = smp_vld && (sector == 4'd1) && (prev_sec != 4'd1);
        acc_load = (state == ST_ARM) && boundary;
        decide   = (state == ST_ACC) && boundary && (seen == ALL_SEEN);
        acc_add  = (state == ST_ACC) && smp_vld && !decide && (grp != GRP_NONE);
    end

    // Sector of the last valid sample, for entry detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_sec <= 4'd0;
        else if (smp_vld)
            prev_sec <= sector;
    end

    // Stage two: grouped saturating error sums and minimum pick.
    err_group_acc #(
        .ERR_W (CUR_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_load),
        .add      (acc_add),
        .grp      (grp),
        .err      (sus_err),
        .best_grp (best_grp)
    );

    // Sequencer: suspect capture, period tracking and verdict latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_WATCH;
            suspect   <= 2'd0;
            seen      <= '0;
            fault_vld <= 1'b0;
            fault_idx <= NO_FAULT;
        end else begin
            case (state)
                ST_WATCH: begin
                    if (|run_full) begin
                        suspect <= first_ph;
                        state   <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (boundary) begin
                        seen  <= sec_bit;
                        state <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (decide) begin
                        fault_vld <= 1'b1;
                        fault_idx <= 4'(suspect) * 4'd3 + 4'(best_grp);
                        state     <= ST_HOLD;
                    end else if (smp_vld) begin
                        seen <= seen | sec_bit;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/osl_checker.sv
// Checker for the open-switch fault locator: port-level temporal
// properties of the verdict outputs. Attached with bind below.
module osl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_vld,
    input logic [3:0] sector,
    input logic       fault_vld,
    input logic [3:0] fault_idx
);
    // R1
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_vld |-> fault_idx == 4'd15);

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> fault_idx <= 4'd8);

    // R10
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> fault_vld && $stable(fault_idx));

    // R5
    verdict_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_vld) |-> $past(smp_vld) && $past(sector) == 4'd1);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(fault_vld));

endmodule

bind open_switch_locator osl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .sector    (sector),
    .fault_vld (fault_vld),
    .fault_idx (fault_idx)
);

// File: tb/sim_open_switch_locator.sv
// Bench: sweeps suspect phase and faulty input with a small configuration,
// expected verdicts computed from saturated group sums in the bench.
module sim_open_switch_locator;
    localparam int CUR_W = 8;
    localparam int DB    = 3;
    localparam int ZRUN  = 4;
    localparam int ACC_W = 8;
    localparam int SPS   = 2;   // samples per sector
    localparam int SMAX  = (1 << ACC_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_vld = 1'b0;
    logic [3:0]              sector = 4'd0;
    logic signed [CUR_W-1:0] cur_a = '0, cur_b = '0, cur_c = '0;
    logic signed [CUR_W-1:0] err_a = '0, err_b = '0, err_c = '0;
    logic                    fault_vld;
    logic [3:0]              fault_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    open_switch_locator #(
        .CUR_W (CUR_W), .DEAD_BAND (DB), .ZERO_RUN (ZRUN), .ACC_W (ACC_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .smp_vld (smp_vld), .sector (sector),
        .cur_a (cur_a), .cur_b (cur_b), .cur_c (cur_c),
        .err_a (err_a), .err_b (err_b), .err_c (err_c),
        .fault_vld (fault_vld), .fault_idx (fault_idx)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic smp(input int sec, input int za, input int zb, input int zc, input int e);
        @(negedge clk);
        smp_vld = 1'b1; sector = 4'(sec);
        cur_a = CUR_W'(za); cur_b = CUR_W'(zb); cur_c = CUR_W'(zc);
        err_a = CUR_W'(e);  err_b = CUR_W'(e);  err_c = CUR_W'(e);
        @(posedge clk);
    endtask

    // Idle cycle: sector 1 and large currents, but no valid sample.
    task automatic idle();
        @(negedge clk);
        smp_vld = 1'b0; sector = 4'd1;
        cur_a = 8'sd100; cur_b = 8'sd100; cur_c = 8'sd100;
        err_a = 8'sd100; err_b = 8'sd100; err_c = 8'sd100;
        @(posedge clk);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    function automatic int grp_of(input int s);
        int k = (s - 1) / 2;
        return (3 - (k % 3)) % 3;
    endfunction

    function automatic int exp_grp(input int e0, input int e1, input int e2);
        int s0 = (e0 * 4 * SPS > SMAX) ? SMAX : e0 * 4 * SPS;
        int s1 = (e1 * 4 * SPS > SMAX) ? SMAX : e1 * 4 * SPS;
        int s2 = (e2 * 4 * SPS > SMAX) ? SMAX : e2 * 4 * SPS;
        if (s0 <= s1 && s0 <= s2) return 0;
        if (s1 <= s2) return 1;
        return 2;
    endfunction

    // Warm-up (sectors 10..12) then one full period; zmask selects the
    // phases held at zval, brk is a warm-up sample index forced out of band.
    task automatic scenario(input int zmask, input int zval, input int brk,
                            input int e0, input int e1, input int e2, input bit gaps);
        for (int i = 0; i < 6; i++) begin
            int z = (i == brk) ? 50 : zval;
            smp(10 + i / 2, zmask[0] ? z : 50, zmask[1] ? z : 50, zmask[2] ? z : 50, 0);
            if (gaps) idle();
        end
        for (int s = 1; s <= 12; s++) begin
            for (int k = 0; k < SPS; k++) begin
                int g = grp_of(s);
                int e = (g == 0) ? e0 : (g == 1) ? e1 : e2;
                smp(s, zmask[0] ? zval : 50, zmask[1] ? zval : 50, zmask[2] ? zval : 50,
                    k[0] ? -e : e);
                if (gaps) idle();
            end
        end
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic final_smp();
        smp(1, 50, 50, 50, 0);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk(fault_vld, 0, "R1 reset vld");
        chk(fault_idx, 15, "R1 reset idx");

        // R6 R7 R5 R12: sweep of suspect phase and faulty input
        for (int p = 0; p < 3; p++) begin
            for (int q = 0; q < 3; q++) begin
                int e0 = (q == 0) ? 2 : 9;
                int e1 = (q == 1) ? 2 : 9;
                int e2 = (q == 2) ? 2 : 9;
                do_reset();
                scenario(1 << p, 0, -1, e0, e1, e2, p == 1);
                chk(fault_vld, 0, "R5 no verdict before closing sample");
                chk(fault_idx, 15, "R1 idle code");
                final_smp();
                chk(fault_vld, 1, "R5 verdict after closing sample");
                chk(fault_idx, p * 3 + exp_grp(e0, e1, e2), "R6 R7 R12 index");
            end
        end

        // R2 dead band edges
        do_reset(); scenario(1, DB, -1, 9, 2, 9, 0); final_smp();
        chk(fault_idx, 1, "R2 +DEAD_BAND in band");
        do_reset(); scenario(4, -DB, -1, 9, 9, 2, 0); final_smp();
        chk(fault_idx, 8, "R2 -DEAD_BAND in band");
        do_reset(); scenario(2, DB + 1, -1, 2, 9, 9, 0); final_smp();
        chk(fault_vld, 0, "R2 +DEAD_BAND+1 out of band");
        do_reset(); scenario(2, -DB - 1, -1, 2, 9, 9, 0); final_smp();
        chk(fault_vld, 0, "R2 -DEAD_BAND-1 out of band");

        // R3 run of exactly ZERO_RUN then a break still detects
        do_reset(); scenario(1, 0, ZRUN, 9, 9, 2, 0); final_smp();
        chk(fault_idx, 2, "R3 run reaching threshold");
        // R4 break after ZERO_RUN-1 restarts the count
        do_reset(); scenario(1, 0, ZRUN - 1, 9, 9, 2, 0); final_smp();
        chk(fault_vld, 0, "R4 broken run gives no early suspect");
        chk(fault_idx, 15, "R3 R4 short run idle code");

        // R8 ties
        do_reset(); scenario(4, 0, -1, 5, 5, 5, 0); final_smp();
        chk(fault_idx, 6 + exp_grp(5, 5, 5), "R8 three-way tie");
        do_reset(); scenario(1, 0, -1, 9, 4, 4, 0); final_smp();
        chk(fault_idx, exp_grp(9, 4, 4), "R8 tie of groups 1 and 2");

        // R9 saturation: groups 0 and 1 clip, group 2 stays below ceiling
        do_reset(); scenario(1, 0, -1, 127, 100, 30, 0); final_smp();
        chk(fault_idx, exp_grp(127, 100, 30), "R9 saturating sums");

        // R11 two phases reach their run together
        do_reset(); scenario(6, 0, -1, 9, 9, 2, 0); final_smp();
        chk(fault_idx, 5, "R11 lowest phase wins");

        // R10 verdict held through a second full scenario
        scenario(1, 0, -1, 2, 9, 9, 0); final_smp();
        chk(fault_vld, 1, "R10 vld held");
        chk(fault_idx, 5, "R10 idx held");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule